// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the data-processing unit of an integer execution stage. Each clock it takes a first operand, an already shifted or rotated second operand, a four-bit operation code, a set-flags request and the current negative, zero, carry and overflow flags. It then produces a result, a destination write enable and the next value of the four flags. All three outputs are registered, so they appear one clock after the inputs are sampled.

Sixteen operations are supported. There are plain and carry-chained adds and subtracts, reverse subtracts that swap the operand roles, the bitwise functions AND, XOR, OR and bit-clear, and move and inverted move. Four flag-only forms (compare, compare-negative, test, test-equivalence) never write the destination and always update the flags. Subtracts that chain a carry take the inverted incoming carry as the borrow.

Logical operations take their carry from a shifter-carry input supplied by the operand-2 path, and they leave the overflow flag as it was. Internally, the block decodes the operation code into a control word, runs a single adder with selectable operand inversion and carry-in, runs a per-bit logic unit, and merges the two in a registered flag stage.

Top module: `int_alu`

## Requirements
- R1: Operation 4 (add) yields A + B; operation 5 (add with carry) yields A + B + C, where A is the first operand, B is operand 2 and C is the incoming carry flag, all modulo 2^WIDTH.
- R2: Operation 2 (subtract) yields A − B; operation 6 (subtract with carry) yields A − B − NOT(C).
- R3: Operation 3 (reverse subtract) yields B − A; operation 7 (reverse subtract with carry) yields B − A − NOT(C).
- R4: The logical operations yield the following: 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 14 gives A AND NOT B, 13 gives B, and 15 gives NOT B.
- R5: Operations 8 (test, A AND B), 9 (test-equivalence, A XOR B), 10 (compare, A − B) and 11 (compare-negative, A + B) leave the write enable low and update the flags whether or not set-flags is asserted.
- R6: When the flags update, N equals the top bit of the operation's value, and Z is 1 exactly when that value is zero.
- R7: When an arithmetic operation updates the flags, C is the carry out of the top bit. For subtract forms this is 1 when no borrow occurs, that is, the carry out of X + NOT(Y) + carry-in.
- R8: When an arithmetic operation updates the flags, V is set on two's-complement overflow. When a logical or move operation updates the flags, V keeps its incoming value.
- R9: When a logical, move, test or test-equivalence operation updates the flags, C takes the shifter-carry input.
- R10: With set-flags low, every operation other than the four flag-only forms passes all four incoming flags through unchanged.
- R11: Every operation other than the four flag-only forms asserts the write enable.
- R12: Under reset, the result, the write enable and all flags read zero. After reset, each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Pre-formed second operand |
| shift_carry | input | 1 | Carry from the operand-2 shifter |
| flag_n | input | 1 | Current negative flag |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| flag_v | input | 1 | Current overflow flag |
| res_q | output | WIDTH | Registered result |
| res_we_q | output | 1 | Registered destination write enable |
| nf_n_q | output | 1 | Next negative flag |
| nf_z_q | output | 1 | Next zero flag |
| nf_c_q | output | 1 | Next carry flag |
| nf_v_q | output | 1 | Next overflow flag |

## Verification
The bench uses an 8-bit build and sweeps every operation code against a grid of edge operands: zero, one, the sign boundary on both sides, all ones, and alternating patterns. It repeats the sweep with set-flags both low and high and with several incoming carry and overflow combinations. A design with an uninverted borrow in the carry-chained subtracts would be off by one whenever C is clear. A design that writes a carry instead of a no-borrow flag on subtraction would get C inverted across the whole subtract sweep. A design that disturbs V on logical operations, or that lets compare and test depend on set-flags or write the destination, breaks checks that compare the outputs against incoming flags that are deliberately nonzero.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_XOR   = 4'd1,
        OP_SUB   = 4'd2,
        OP_RSUB  = 4'd3,
        OP_ADD   = 4'd4,
        OP_ADDC  = 4'd5,
        OP_SUBC  = 4'd6,
        OP_RSUBC = 4'd7,
        OP_TEST  = 4'd8,
        OP_TEQV  = 4'd9,
        OP_CMP   = 4'd10,
        OP_CMPN  = 4'd11,
        OP_OR    = 4'd12,
        OP_MOVE  = 4'd13,
        OP_CLR   = 4'd14,
        OP_MOVN  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [2:0] {
        LF_AND  = 3'd0,
        LF_XOR  = 3'd1,
        LF_OR   = 3'd2,
        LF_CLR  = 3'd3,
        LF_PASS = 3'd4,
        LF_INV  = 3'd5
    } logic_fn_e;

    typedef struct packed {
        logic      is_arith;
        logic      writes;
        logic      flags_forced;
        logic      inv_x;
        logic      inv_y;
        cin_sel_e  cin_sel;
        logic_fn_e lfn;
    } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctrl_t  ctrl
);

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    always_comb begin
        ctrl              = '0;
        ctrl.cin_sel      = CIN_ZERO;
        ctrl.lfn          = LF_AND;
        ctrl.writes       = 1'b1;
        unique case (op)
            OP_ADD, OP_CMPN: begin
                ctrl.is_arith = 1'b1;
            end
            OP_ADDC: begin
                ctrl.is_arith = 1'b1;
                ctrl.cin_sel  = CIN_FLAG;
            end
            OP_SUB, OP_CMP: begin
                ctrl.is_arith = 1'b1;
                ctrl.inv_y    = 1'b1;
                ctrl.cin_sel  = CIN_ONE;
            end
            OP_SUBC: begin
                ctrl.is_arith = 1'b1;
                ctrl.inv_y    = 1'b1;
                ctrl.cin_sel  = CIN_FLAG;
            end
            OP_RSUB: begin
                ctrl.is_arith = 1'b1;
                ctrl.inv_x    = 1'b1;
                ctrl.cin_sel  = CIN_ONE;
            end
            OP_RSUBC: begin
                ctrl.is_arith = 1'b1;
                ctrl.inv_x    = 1'b1;
                ctrl.cin_sel  = CIN_FLAG;
            end
            OP_AND, OP_TEST: ctrl.lfn = LF_AND;
            OP_XOR, OP_TEQV: ctrl.lfn = LF_XOR;
            OP_OR:           ctrl.lfn = LF_OR;
            OP_CLR:          ctrl.lfn = LF_CLR;
            OP_MOVE:         ctrl.lfn = LF_PASS;
            OP_MOVN:         ctrl.lfn = LF_INV;
            default:         ctrl.lfn = LF_AND;
        endcase
        if (op == OP_TEST || op == OP_TEQV || op == OP_CMP || op == OP_CMPN) begin
            ctrl.writes       = 1'b0;
            ctrl.flags_forced = 1'b1;
        end
    end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int EXT = WIDTH + 1;
    localparam int MSB = WIDTH - 1;

    logic [EXT-1:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{(EXT-1){1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        lfn,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (lfn)
                LF_AND:  y[i] = a[i] & b[i];
                LF_XOR:  y[i] = a[i] ^ b[i];
                LF_OR:   y[i] = a[i] | b[i];
                LF_CLR:  y[i] = a[i] & ~b[i];
                LF_PASS: y[i] = b[i];
                LF_INV:  y[i] = ~b[i];
                default: y[i] = a[i] & b[i];
            endcase
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_code,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             shift_carry,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic             flag_v,
    output logic [WIDTH-1:0] res_q,
    output logic             res_we_q,
    output logic             nf_n_q,
    output logic             nf_z_q,
    output logic             nf_c_q,
    output logic             nf_v_q
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] add_x, add_y, add_sum, log_y, value_d;
    logic             add_cin, add_cout, add_ovf, upd_d;
    logic             n_d, z_d, c_d, v_d;
    logic             primed_q;

    int_alu_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    always_comb begin
        add_x = ctrl.inv_x ? ~opnd_a : opnd_a;
        add_y = ctrl.inv_y ? ~opnd_b : opnd_b;
        unique case (ctrl.cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = flag_c;
            default:  add_cin = 1'b0;
        endcase
    end

    int_alu_adder #(.WIDTH(WIDTH)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    int_alu_logic #(.WIDTH(WIDTH)) u_log (
        .a   (opnd_a),
        .b   (opnd_b),
        .lfn (ctrl.lfn),
        .y   (log_y)
    );

    always_comb begin
        value_d = ctrl.is_arith ? add_sum : log_y;
        upd_d   = set_flags | ctrl.flags_forced;
        n_d     = flag_n;
        z_d     = flag_z;
        c_d     = flag_c;
        v_d     = flag_v;
        if (upd_d) begin
            n_d = value_d[MSB];
            z_d = (value_d == '0);
            c_d = ctrl.is_arith ? add_cout : shift_carry;
            v_d = ctrl.is_arith ? add_ovf : flag_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            res_we_q <= 1'b0;
            nf_n_q   <= 1'b0;
            nf_z_q   <= 1'b0;
            nf_c_q   <= 1'b0;
            nf_v_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            res_q    <= value_d;
            res_we_q <= ctrl.writes;
            nf_n_q   <= n_d;
            nf_z_q   <= z_d;
            nf_c_q   <= c_d;
            nf_v_q   <= v_d;
            primed_q <= 1'b1;
        end
    end

    // R5
    no_write_flagonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op_code[3:2] == 2'b10)) |-> !res_we_q);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(set_flags) && $past(op_code[3:2] != 2'b10)) |->
        ({nf_n_q, nf_z_q, nf_c_q, nf_v_q} ==
         $past({flag_n, flag_z, flag_c, flag_v})));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(set_flags)) |->
        (nf_z_q == (res_q == '0)) && (nf_n_q == res_q[MSB]));

    // R8
    logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && ($past(op_code) inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
        |-> (nf_v_q == $past(flag_v)));

    // R11
    write_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op_code[3:2] != 2'b10)) |-> res_we_q);

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   op_code;
    logic         set_flags;
    logic [W-1:0] opnd_a, opnd_b;
    logic         shift_carry, flag_n, flag_z, flag_c, flag_v;
    logic [W-1:0] res_q;
    logic         res_we_q, nf_n_q, nf_z_q, nf_c_q, nf_v_q;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    int_alu #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .set_flags(set_flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_carry(shift_carry),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .res_q(res_q), .res_we_q(res_we_q), .nf_n_q(nf_n_q), .nf_z_q(nf_z_q),
        .nf_c_q(nf_c_q), .nf_v_q(nf_v_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (op=%0d a=%0h b=%0h sf=%0b c=%0b v=%0b)",
                     req, what, act, exp, op_code, opnd_a, opnd_b, set_flags, flag_c, flag_v);
        end
    endtask

    task automatic model_and_check();
        int ua, ub, sa, sb, bor, full, sres;
        int val;
        bit arith, flagonly, upd, en, ec, ev, en_n, ez;
        string rreq;
        ua = int'(opnd_a); ub = int'(opnd_b);
        sa = int'($signed(opnd_a)); sb = int'($signed(opnd_b));
        bor = flag_c ? 0 : 1;
        arith = 1'b1; full = 0; sres = 0; val = 0; rreq = "R4";
        case (op_code)
            4'd4, 4'd11: begin full = ua + ub; sres = sa + sb; rreq = "R1"; end
            4'd5: begin full = ua + ub + int'(flag_c); sres = sa + sb + int'(flag_c); rreq = "R1"; end
            4'd2, 4'd10: begin full = ua - ub; sres = sa - sb; rreq = "R2"; end
            4'd6: begin full = ua - ub - bor; sres = sa - sb - bor; rreq = "R2"; end
            4'd3: begin full = ub - ua; sres = sb - sa; rreq = "R3"; end
            4'd7: begin full = ub - ua - bor; sres = sb - sa - bor; rreq = "R3"; end
            default: arith = 1'b0;
        endcase
        if (arith) begin
            val = full & 8'hFF;
            if (op_code inside {4'd4, 4'd5, 4'd11}) ec = (full > 255);
            else ec = (full >= 0);
            ev = (sres > 127) || (sres < -128);
        end else begin
            case (op_code)
                4'd0, 4'd8: val = ua & ub;
                4'd1, 4'd9: val = ua ^ ub;
                4'd12:      val = ua | ub;
                4'd14:      val = ua & (~ub & 8'hFF);
                4'd13:      val = ub;
                default:    val = (~ub) & 8'hFF;
            endcase
            ec = shift_carry;
            ev = flag_v;
        end
        flagonly = (op_code >= 4'd8) && (op_code <= 4'd11);
        upd = set_flags || flagonly;
        en = !flagonly;
        if (en) chk(rreq, "result", int'(res_q), val);
        chk(flagonly ? "R5" : "R11", "write enable", int'(res_we_q), int'(en));
        if (upd) begin
            en_n = val[7];
            ez = (val == 0);
            chk("R6", "N", int'(nf_n_q), int'(en_n));
            chk("R6", "Z", int'(nf_z_q), int'(ez));
            chk(arith ? "R7" : "R9", "C", int'(nf_c_q), int'(ec));
            chk("R8", "V", int'(nf_v_q), int'(ev));
        end else begin
            chk("R10", "flags held", int'({nf_n_q, nf_z_q, nf_c_q, nf_v_q}),
                int'({flag_n, flag_z, flag_c, flag_v}));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pts [12];
        pts = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF,
                8'h55, 8'hAA, 8'h0F, 8'h40};
        rst_n = 1'b0; op_code = 4'd4; set_flags = 1'b1;
        opnd_a = 8'hFF; opnd_b = 8'h01; shift_carry = 1'b1;
        flag_n = 1'b1; flag_z = 1'b1; flag_c = 1'b1; flag_v = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12", "reset outputs",
            int'({res_q, res_we_q, nf_n_q, nf_z_q, nf_c_q, nf_v_q}), 0);
        rst_n = 1'b1;
        // R12: one-cycle latency, first captured value
        op_code = 4'd4; set_flags = 1'b0; opnd_a = 8'h12; opnd_b = 8'h34;
        @(negedge clk);
        chk("R12", "latency result", int'(res_q), 8'h46);
        for (int op = 0; op < 16; op++) begin
            for (int sf = 0; sf < 2; sf++) begin
                for (int fl = 0; fl < 4; fl++) begin
                    for (int ia = 0; ia < 12; ia++) begin
                        for (int ib = 0; ib < 12; ib++) begin
                            op_code = 4'(op);
                            set_flags = sf[0];
                            flag_c = fl[0];
                            flag_v = fl[1];
                            flag_n = fl[1];
                            flag_z = ~fl[0];
                            shift_carry = ia[0] ^ ib[1] ^ fl[0];
                            opnd_a = pts[ia];
                            opnd_b = pts[ib];
                            @(negedge clk);
                            model_and_check();
                        end
                    end
                end
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule